// File: doc/BRIEF.md
# Masked Fast GPIO Port Controller

This block is a 32-bit general-purpose I/O port reached through a simple local register bus. Software decides per bit whether a pad is driven, writes the output data either as a whole-port value or through set-only and clear-only registers, and reads back both the output data register and the live pad levels. The block drives an output-enable vector and an output-data vector toward the pads. It samples the pad inputs through a two-flop synchronizer.

A mask register lets software treat a group of port bits as one field. Bits that are masked are protected from whole-port, set and clear writes, and they read as zero on a pin read. Every register accepts partial writes through four byte-enable strobes. Reads are registered: the data and a valid pulse appear one clock after the request.

Register word addresses (`bus_addr`): 0 direction, 1 mask, 2 output data, 3 set, 4 clear, 5 pin value. Addresses 6 and 7 are unmapped.

Top module: `mgpio_port`

## Requirements
- R1: After a synchronous active-low reset the direction, mask and output data registers are all zero, so `pad_oe` and `pad_out` are zero and `rd_valid` is low.
- R2: Direction bit i set to 1 makes pin i an output (`pad_oe[i]`=1) and 0 makes it an input. The direction register reads back at address 0.
- R3: A write to address 2 replaces every unmasked output bit in the enabled lanes in one cycle. Masked bits keep their value.
- R4: A write to address 3 sets the output bits written as 1 in enabled lanes. Bits written as 0, and masked bits, are unchanged.
- R5: A write to address 4 clears the output bits written as 1 in enabled lanes. Bits written as 0, and masked bits, are unchanged.
- R6: `bus_be[k]` enables bits 8k+7..8k of a write to any register. Lanes not enabled keep their old contents.
- R7: A read of address 2 returns the full output data register, masked bits included.
- R8: A read of address 5 returns the synchronized pad levels ANDed with the inverted mask. A pad level changed just before clock edge n is returned by a read accepted at edge n+2, and not by one accepted at edge n+1.
- R9: A read request (`bus_sel`=1, `bus_wr`=0) gives `rd_valid`=1 and `rd_data` on the following cycle. Writes give no `rd_valid`. Reads of addresses 3, 4, 6 and 7 return zero. Writes to addresses 5, 6 and 7 change no register.
- R10: The mask register is written at address 1 and reads back there. A 1 marks a bit as masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register word address |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | One-cycle pulse marking valid `rd_data` |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_oe | output | 32 | Per-pin output enable toward the pads |
| pad_out | output | 32 | Per-pin output data toward the pads |

## Verification
Register writes take effect on the edge that accepts them. The bench therefore checks `pad_oe` and `pad_out` at the falling edge right after that edge. Read data is due one cycle after the request, so each read task drives the request at a falling edge and samples `rd_data` and `rd_valid` at the next falling edge. Pad levels need two edges through the synchronizer before a read can capture them. The bench waits exactly two cycles after each pad change before it reads, and one directed case reads after only one cycle to confirm that the old level is still returned.

// File: rtl/mgpio_pkg.sv
// Package: shared register addresses and write-strobe type for the
// masked GPIO port. Assumes a word-addressed register bus.
package mgpio_pkg;

    localparam int unsigned REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_DIR  = 3'd0,
        RA_MASK = 3'd1,
        RA_OUT  = 3'd2,
        RA_SET  = 3'd3,
        RA_CLR  = 3'd4,
        RA_PIN  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic wr_dir;
        logic wr_mask;
        logic wr_out;
        logic wr_set;
        logic wr_clr;
    } wr_strobe_t;

endpackage

// File: rtl/mgpio_decode.sv
// Module: mgpio_decode
// Turns one bus access into per-register write strobes and a read request.
// Assumes at most one access per cycle; unmapped or read-only addresses
// produce no strobe.
module mgpio_decode
    import mgpio_pkg::*;
(
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    output wr_strobe_t            wstb,
    output logic                  rd_req
);

    // Decode write target from the address.
    always_comb begin
        wstb = '0;
        if (bus_sel && bus_wr) begin
            case (reg_addr_e'(bus_addr))
                RA_DIR:  wstb.wr_dir  = 1'b1;
                RA_MASK: wstb.wr_mask = 1'b1;
                RA_OUT:  wstb.wr_out  = 1'b1;
                RA_SET:  wstb.wr_set  = 1'b1;
                RA_CLR:  wstb.wr_clr  = 1'b1;
                default: wstb = '0;
            endcase
        end
    end

    // A read is any selected access without the write flag.
    assign rd_req = bus_sel && !bus_wr;

endmodule

// File: rtl/mgpio_lane_reg.sv
// Module: mgpio_lane_reg
// Plain register with byte-lane write enables and a parameter reset value.
// Assumes WIDTH is a multiple of 8.
module mgpio_lane_reg #(
    parameter int unsigned       WIDTH     = 32,
    parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WIDTH/8-1:0]   be,
    input  logic [WIDTH-1:0]     wdata,
    output logic [WIDTH-1:0]     q
);

    localparam int unsigned LANES = WIDTH / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_q;

        // Hold or load one byte lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= RESET_VAL[g*8 +: 8];
            end else if (wr_en && be[g]) begin
                lane_q <= wdata[g*8 +: 8];
            end
        end

        assign q[g*8 +: 8] = lane_q;
    end

endmodule

// File: rtl/mgpio_out_ctrl.sv
// Module: mgpio_out_ctrl
// Output data register updated by whole-port, set and clear writes.
// Only bits that are both in an enabled lane and unmasked may change.
// Assumes WIDTH is a multiple of 8; clear takes priority over set.
module mgpio_out_ctrl #(
    parameter int unsigned WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_out,
    input  logic               wr_set,
    input  logic               wr_clr,
    input  logic [WIDTH/8-1:0] be,
    input  logic [WIDTH-1:0]   wdata,
    input  logic [WIDTH-1:0]   mask,
    output logic [WIDTH-1:0]   q
);

    localparam int unsigned LANES = WIDTH / 8;

    logic [WIDTH-1:0] lane_bits;
    logic [WIDTH-1:0] open_bits;
    logic [WIDTH-1:0] base_val;
    logic [WIDTH-1:0] set_bits;
    logic [WIDTH-1:0] clr_bits;
    logic [WIDTH-1:0] q_next;

    for (genvar g = 0; g < LANES; g++) begin : g_lane_exp
        assign lane_bits[g*8 +: 8] = {8{be[g]}};
    end

    // Bits that this write is permitted to touch.
    assign open_bits = lane_bits & ~mask;

    // Next-state value: port write first, then set, then clear wins.
    always_comb begin
        base_val = wr_out ? ((q & ~open_bits) | (wdata & open_bits)) : q;
        set_bits = wr_set ? (wdata & open_bits) : '0;
        clr_bits = wr_clr ? (wdata & open_bits) : '0;
        q_next   = (base_val | set_bits) & ~clr_bits;
    end

    // Output data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/mgpio_sync.sv
// Module: mgpio_sync
// Multi-stage flop synchronizer for asynchronous pad inputs.
// Assumes each bit is independent; no bus coherency is promised.
module mgpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the pad sample one stage along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[s] <= '0;
            end else if (s == 0) begin
                chain[s] <= d;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/mgpio_rd_port.sv
// Module: mgpio_rd_port
// Registered read multiplexer. Data and a valid pulse follow the request
// by one cycle. Pin reads hide masked bits; write-only and unmapped
// addresses read as zero.
module mgpio_rd_port
    import mgpio_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_req,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    input  logic [WIDTH-1:0]      dir_q,
    input  logic [WIDTH-1:0]      mask_q,
    input  logic [WIDTH-1:0]      out_q,
    input  logic [WIDTH-1:0]      pin_q,
    output logic [WIDTH-1:0]      rd_data,
    output logic                  rd_valid
);

    logic [WIDTH-1:0] sel_data;

    // Choose the source for the addressed register.
    always_comb begin
        case (reg_addr_e'(rd_addr))
            RA_DIR:  sel_data = dir_q;
            RA_MASK: sel_data = mask_q;
            RA_OUT:  sel_data = out_q;
            RA_PIN:  sel_data = pin_q & ~mask_q;
            default: sel_data = '0;
        endcase
    end

    // Capture read data and raise the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_data <= sel_data;
            end
        end
    end

endmodule

// File: rtl/mgpio_port.sv
// Module: mgpio_port (top)
// Masked GPIO port: direction, mask and output registers with byte-lane
// writes, set/clear updates, and synchronized pin reads.
// Assumes a single-access-per-cycle register bus and asynchronous pads.
module mgpio_port
    import mgpio_pkg::*;
#(
    parameter int unsigned WIDTH       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH/8-1:0]    bus_be,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      rd_data,
    output logic                  rd_valid,
    input  logic [WIDTH-1:0]      pad_in,
    output logic [WIDTH-1:0]      pad_oe,
    output logic [WIDTH-1:0]      pad_out
);

    wr_strobe_t       wstb;
    logic             rd_req;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] pin_q;

    mgpio_decode u_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wstb     (wstb),
        .rd_req   (rd_req)
    );

    mgpio_lane_reg #(.WIDTH(WIDTH), .RESET_VAL('0)) u_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wstb.wr_dir),
        .be    (bus_be),
        .wdata (bus_wdata),
        .q     (dir_q)
    );

    mgpio_lane_reg #(.WIDTH(WIDTH), .RESET_VAL('0)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wstb.wr_mask),
        .be    (bus_be),
        .wdata (bus_wdata),
        .q     (mask_q)
    );

    mgpio_out_ctrl #(.WIDTH(WIDTH)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_out (wstb.wr_out),
        .wr_set (wstb.wr_set),
        .wr_clr (wstb.wr_clr),
        .be     (bus_be),
        .wdata  (bus_wdata),
        .mask   (mask_q),
        .q      (out_q)
    );

    mgpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_q)
    );

    mgpio_rd_port #(.WIDTH(WIDTH)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rd_addr  (bus_addr),
        .dir_q    (dir_q),
        .mask_q   (mask_q),
        .out_q    (out_q),
        .pin_q    (pin_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign pad_oe  = dir_q;
    assign pad_out = out_q;

endmodule

// File: rtl/mgpio_port_chk.sv
// Module: mgpio_port_chk
// Temporal checks on the masked GPIO port, bound to the top module.
// Assumes the top's internal mask register is named mask_q.
module mgpio_port_chk
    import mgpio_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]      rd_data,
    input logic                  rd_valid,
    input logic [WIDTH-1:0]      pad_oe,
    input logic [WIDTH-1:0]      pad_out,
    input logic [WIDTH-1:0]      mask_q
);

    AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0)); // R1

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == RA_DIR) |=> $stable(pad_oe)); // R2

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> ((pad_out ^ $past(pad_out)) & $past(mask_q)) == '0); // R3

    AST_SET_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == RA_SET) |=> ((~pad_out & $past(pad_out)) == '0)); // R4

    AST_CLR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == RA_CLR) |=> ((pad_out & ~$past(pad_out)) == '0)); // R5

    AST_PIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == RA_PIN) |=> ((rd_data & $past(mask_q)) == '0)); // R8

    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr) |=> !rd_valid); // R9

endmodule

bind mgpio_port mgpio_port_chk #(.WIDTH(WIDTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .mask_q   (mask_q)
);

// File: tb/mgpio_port_tb_top.sv
`timescale 1ns/1ps
module mgpio_port_tb_top;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_sel;
    logic          bus_wr;
    logic [2:0]    bus_addr;
    logic [3:0]    bus_be;
    logic [W-1:0]  bus_wdata;
    logic [W-1:0]  rd_data;
    logic          rd_valid;
    logic [W-1:0]  pad_in;
    logic [W-1:0]  pad_oe;
    logic [W-1:0]  pad_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [W-1:0] dir_m, mask_m, out_m, pin_m;

    always #2 clk = ~clk;

    mgpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] lanes(input logic [3:0] be);
        logic [W-1:0] m = '0;
        for (int k = 0; k < 4; k++) if (be[k]) m[k*8 +: 8] = 8'hFF;
        return m;
    endfunction

    // Model update for one write (R2..R6, R9, R10).
    task automatic model_write(input logic [2:0] a, input logic [3:0] be, input logic [W-1:0] d);
        logic [W-1:0] lm = lanes(be);
        logic [W-1:0] op = lm & ~mask_m;
        case (a)
            3'd0: dir_m  = (dir_m & ~lm) | (d & lm);
            3'd1: mask_m = (mask_m & ~lm) | (d & lm);
            3'd2: out_m  = (out_m & ~op) | (d & op);
            3'd3: out_m  = out_m | (d & op);
            3'd4: out_m  = out_m & ~(d & op);
            default: ;
        endcase
    endtask

    function automatic logic [W-1:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return dir_m;
            3'd1: return mask_m;
            3'd2: return out_m;
            3'd5: return pin_m & ~mask_m;
            default: return '0;
        endcase
    endfunction

    // Tasks start and end at a falling edge.
    task automatic bus_write(input logic [2:0] a, input logic [3:0] be, input logic [W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        model_write(a, be, d);
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [W-1:0] d, output logic v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = '0;
        @(negedge clk);
        bus_sel = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic chk_read(input string req, input logic [2:0] a);
        logic [W-1:0] d; logic v;
        bus_read(a, d, v);
        chk({req, " valid"}, {31'd0, v}, 32'd1);
        chk(req, d, exp_read(a));
    endtask

    task automatic set_pads(input logic [W-1:0] p);
        pad_in = p;
        repeat (2) @(negedge clk);
        pin_m = p;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d; logic v;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
        bus_be = '0; bus_wdata = '0; pad_in = '0;
        dir_m = '0; mask_m = '0; out_m = '0; pin_m = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_out", pad_out, '0);
        chk("R1 rd_valid", {31'd0, rd_valid}, '0);
        chk_read("R1 mask", 3'd1);

        // R2: direction
        bus_write(3'd0, 4'hF, 32'hFFFF_00F0);
        chk("R2 pad_oe", pad_oe, 32'hFFFF_00F0);
        chk_read("R2 dir readback", 3'd0);

        // R3 / R7: port write, no mask
        bus_write(3'd2, 4'hF, 32'hA5A5_5A5A);
        chk("R3 pad_out", pad_out, 32'hA5A5_5A5A);
        // R10 / R3: mask protects low half
        bus_write(3'd1, 4'hF, 32'h0000_FFFF);
        chk_read("R10 mask readback", 3'd1);
        bus_write(3'd2, 4'hF, 32'h0000_0000);
        chk("R3 masked hold", pad_out, 32'h0000_5A5A);
        chk_read("R7 out readback", 3'd2);

        // R4 / R5: set and clear
        bus_write(3'd3, 4'hF, 32'hFFFF_FFFF);
        chk("R4 set", pad_out, 32'hFFFF_5A5A);
        bus_write(3'd3, 4'hF, 32'h0000_0000);
        chk("R4 zero no effect", pad_out, 32'hFFFF_5A5A);
        bus_write(3'd4, 4'hF, 32'h0F0F_0F0F);
        chk("R5 clear", pad_out, 32'hF0F0_5A5A);

        // R6: byte lanes
        bus_write(3'd1, 4'hF, 32'h0);
        bus_write(3'd2, 4'b0100, 32'h1122_3344);
        chk("R6 out lane", pad_out, 32'hF022_5A5A);
        bus_write(3'd0, 4'b1001, 32'h0000_0000);
        chk("R6 dir lane", pad_oe, 32'h00FF_0000);

        // R8: pin read latency and masking
        bus_write(3'd1, 4'hF, 32'h0000_00FF);
        pad_in = 32'hDEAD_BEEF;
        @(negedge clk);
        bus_read(3'd5, d, v);
        chk("R8 one cycle still old", d, 32'h0);
        pin_m = 32'hDEAD_BEEF;
        chk_read("R8 pin masked", 3'd5);

        // R9: write-only / unmapped reads, ignored writes
        chk_read("R9 set reads zero", 3'd3);
        chk_read("R9 unmapped reads zero", 3'd7);
        bus_write(3'd5, 4'hF, 32'hFFFF_FFFF);
        chk("R9 write no valid", {31'd0, rd_valid}, '0);
        bus_write(3'd6, 4'hF, 32'hFFFF_FFFF);
        chk_read("R9 out unchanged", 3'd2);
        chk_read("R9 dir unchanged", 3'd0);
        chk_read("R9 mask unchanged", 3'd1);

        // Random mix, checked against the model
        for (int i = 0; i < 500; i++) begin
            logic [2:0] a;
            a = 3'($urandom_range(0, 7));
            if (i % 60 == 0) set_pads($urandom);
            if ($urandom_range(0, 2) != 0) begin
                bus_write(a, 4'($urandom), $urandom);
                chk("R2 random pad_oe", pad_oe, dir_m);
                chk("R3 R4 R5 R6 random pad_out", pad_out, out_m);
            end else begin
                chk_read("R7 R8 R9 random read", a);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule